// File: doc/BRIEF.md
# Command-List Walk Sequencer

This block is the fetch and sequencing front end of one data-mover channel. The host writes a command-pointer word. The upper three bits of that word choose how it is read, and the lower 29 bits hold an 8-byte-aligned address stored right-shifted by three. In pointer mode the engine reads a chain of 32-bit pointer entries. Each entry names an array of 16-byte command records. In direct mode the address names one such array. Every record is fetched as four words and handed to a downstream transfer engine as one descriptor. The engine does not move any data itself.

Two in-band flags end the walk. Bit 31 of a pointer entry marks the final entry. Bit 31 of a record's command word marks the final record in its array. When the walk ends, the engine posts a result word into a small queue that the host drains. A status word reports whether the engine is idle, whether a result is waiting, and how many results are queued. An interrupt is raised while results are waiting, if the host has enabled it. Memory is read through a single-outstanding request/response port.

The walker state machine has seven states. `ST_IDLE` accepts a write. It goes to `ST_PTR_REQ` in pointer mode, to `ST_REC_REQ` in direct mode, and to `ST_POST` for any other mode. `ST_PTR_REQ` always goes to `ST_PTR_WAIT`, which moves to `ST_REC_REQ` when the response arrives. `ST_REC_REQ` always goes to `ST_REC_WAIT`. On each response, `ST_REC_WAIT` does one of three things:
- after word 0, if the record's mode field is not single-item, it goes to `ST_POST`;
- after word 3, it goes to `ST_DESC`;
- otherwise it goes back to `ST_REC_REQ` for the next word.

`ST_DESC` waits for the downstream handshake. It then goes to `ST_REC_REQ` for the next record, to `ST_PTR_REQ` for the next pointer entry, or to `ST_POST` when the walk is over. `ST_POST` returns to `ST_IDLE` once the result queue has room.

Top module: `cmdlist_seq`

## Requirements
- R1: After reset the status word is 0x00000001 (idle, no result, zero queued). `irq`, `mem_req` and `desc_valid` are low, and reading the result port returns 0.
- R2: A command-pointer write while idle starts the walk at the next clock edge. Status bit 0 drops in the following cycle. The first memory read is at byte address `cptr_wdata[28:0]` shifted left by 3. Only one read is outstanding at a time.
- R3: With `cptr_wdata[31:29]` = 1 (pointer mode), entries are read at consecutive 4-byte addresses. Entry bits 28:0 shifted left by 3 give the byte address of a record array. The walk ends after the array of the entry whose bit 31 is set.
- R4: Each record is four words at consecutive addresses: command, source, destination, length. They are presented together on `desc_cmd`, `desc_src`, `desc_dst` and `desc_len`, in memory order. They are held stable while `desc_valid` is high and `desc_ready` is low.
- R5: A record whose command bit 31 is set is the last one in its array. With `cptr_wdata[31:29]` = 0 (direct mode), the walk ends after that record.
- R6: A record whose command bits 1:0 are not 0 (not single-item) is not forwarded. The walk ends and posts the result 0x80000008 (bit 31 valid, bit 3 error).
- R7: A list-mode value of 2 to 7 issues no memory read and posts the result 0x80000008.
- R8: A walk that ends normally posts 0x80000002 (bit 31 valid, bit 1 done, bit 2 flush always 0). `rslt_rdata` shows the oldest queued result, and a cycle with `rslt_rd` high removes it. With the queue empty, `rslt_rdata` reads 0.
- R9: The status word has these fields: bit 0 is idle and able to accept a pointer, bit 1 is a result is queued, bits 31:29 are the queue occupancy, and all other bits are 0.
- R10: The result queue holds `RES_DEPTH` (default 4) words. When it is full, the engine waits in its posting state with status bit 0 low. It posts as soon as the host removes an entry.
- R11: A command-pointer write while status bit 0 is low has no effect. It causes no extra descriptors, reads or results.
- R12: `irq` is high exactly while the interrupt enable is set and a result is queued. The enable is loaded from `cfg_irq_en` when `cfg_wr` is high, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cptr_wr | input | 1 | Command-pointer write strobe |
| cptr_wdata | input | 32 | Command-pointer word: list mode in 31:29, address/8 in 28:0 |
| cfg_wr | input | 1 | Config write strobe |
| cfg_irq_en | input | 1 | Interrupt enable value written by `cfg_wr` |
| rslt_rd | input | 1 | Result read strobe; removes the head entry |
| rslt_rdata | output | 32 | Head of the result queue, 0 when empty |
| status | output | 32 | Status word |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Downstream accepts descriptor |
| desc_cmd | output | 32 | Descriptor command word |
| desc_src | output | 32 | Descriptor source address |
| desc_dst | output | 32 | Descriptor destination address |
| desc_len | output | 32 | Descriptor length |

## Verification
The bench builds the block with the default `RES_DEPTH` of 4. Four completed walks with no reads are therefore enough to fill the queue and hold a fifth walk in its posting state. This puts the full-queue stall and its release within a few hundred cycles. Random pointer chains of one to four entries, arrays of one to three records, memory latencies of one to three cycles and downstream stalls of up to 100 percent exercise every transition of the walker. These include a busy engine receiving an ignored pointer write.

// File: rtl/cls_pkg.sv
package cls_pkg;

    localparam int WORD_W    = 32;
    localparam int REC_WORDS = 4;
    localparam int REC_IDX_W = $clog2(REC_WORDS);
    localparam int REC_BYTES = REC_WORDS * 4;

    // list-mode selector values carried in cptr_wdata[31:29]
    localparam logic [2:0] LMODE_DIRECT = 3'd0;
    localparam logic [2:0] LMODE_PTRS   = 3'd1;

    // result word bit positions
    localparam int RES_VALID_BIT = 31;
    localparam int RES_ERR_BIT   = 3;
    localparam int RES_FLUSH_BIT = 2;
    localparam int RES_DONE_BIT  = 1;

    localparam int LAST_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR_REQ,
        ST_PTR_WAIT,
        ST_REC_REQ,
        ST_REC_WAIT,
        ST_DESC,
        ST_POST
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
    } desc_t;

    // stored address field (addr >> 3) back to a byte address
    function automatic logic [WORD_W-1:0] field_to_byte(input logic [WORD_W-1:0] w);
        return {w[WORD_W-4:0], 3'b000};
    endfunction

endpackage

// File: rtl/cls_result_fifo.sv
module cls_result_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;
    logic [WIDTH-1:0] slot_w [DEPTH];

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = count_q;
    assign head    = slot_w[rd_ptr_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] data_q;
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr_q == PTR_W'(i)) begin
                data_q <= push_data;
            end
        end
        assign slot_w[i] = data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/cls_walker.sv
module cls_walker
    import cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_word,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              desc_valid,
    output desc_t             desc,
    input  logic              desc_ready,
    input  logic              post_ok,
    output logic              post_push,
    output logic [WORD_W-1:0] post_word,
    output logic              idle
);
    walk_state_e state_q, nstate;

    logic [WORD_W-1:0]    ptr_addr_q;
    logic [WORD_W-1:0]    rec_addr_q;
    logic                 ptr_mode_q;
    logic                 last_ptr_q;
    logic                 err_q;
    logic [REC_IDX_W-1:0] widx_q;
    logic [WORD_W-1:0]    rec_q [REC_WORDS];

    logic [2:0] start_mode;
    logic       word_last;
    logic       bad_rec_mode;
    logic       rec_last;

    assign start_mode   = start_word[31:29];
    assign word_last    = (widx_q == REC_IDX_W'(REC_WORDS - 1));
    assign bad_rec_mode = (widx_q == '0) && (mem_rdata[1:0] != 2'b00);
    assign rec_last     = rec_q[0][LAST_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (start_mode == LMODE_PTRS)        nstate = ST_PTR_REQ;
                    else if (start_mode == LMODE_DIRECT) nstate = ST_REC_REQ;
                    else                                 nstate = ST_POST;
                end
            end
            ST_PTR_REQ:  nstate = ST_PTR_WAIT;
            ST_PTR_WAIT: if (mem_rvalid) nstate = ST_REC_REQ;
            ST_REC_REQ:  nstate = ST_REC_WAIT;
            ST_REC_WAIT: begin
                if (mem_rvalid) begin
                    if (bad_rec_mode)   nstate = ST_POST;
                    else if (word_last) nstate = ST_DESC;
                    else                nstate = ST_REC_REQ;
                end
            end
            ST_DESC: begin
                if (desc_ready) begin
                    if (!rec_last)                     nstate = ST_REC_REQ;
                    else if (ptr_mode_q && !last_ptr_q) nstate = ST_PTR_REQ;
                    else                               nstate = ST_POST;
                end
            end
            ST_POST:     if (post_ok) nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        mem_req    = 1'b0;
        desc_valid = 1'b0;
        post_push  = 1'b0;
        idle       = 1'b0;
        mem_addr   = rec_addr_q + (WORD_W'(widx_q) << 2);
        unique case (state_q)
            ST_IDLE:     idle = 1'b1;
            ST_PTR_REQ: begin
                mem_req  = 1'b1;
                mem_addr = ptr_addr_q;
            end
            ST_REC_REQ:  mem_req = 1'b1;
            ST_DESC:     desc_valid = 1'b1;
            ST_POST:     post_push = 1'b1;
            default: ;
        endcase
    end

    assign desc.cmd = rec_q[0];
    assign desc.src = rec_q[1];
    assign desc.dst = rec_q[2];
    assign desc.len = rec_q[3];

    always_comb begin
        post_word                = '0;
        post_word[RES_VALID_BIT] = 1'b1;
        post_word[RES_ERR_BIT]   = err_q;
        post_word[RES_FLUSH_BIT] = 1'b0;
        post_word[RES_DONE_BIT]  = !err_q;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_addr_q <= '0;
            rec_addr_q <= '0;
            ptr_mode_q <= 1'b0;
            last_ptr_q <= 1'b0;
            err_q      <= 1'b0;
            widx_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ptr_addr_q <= field_to_byte(start_word);
                        rec_addr_q <= field_to_byte(start_word);
                        ptr_mode_q <= (start_mode == LMODE_PTRS);
                        last_ptr_q <= 1'b0;
                        err_q      <= (start_mode != LMODE_PTRS) && (start_mode != LMODE_DIRECT);
                        widx_q     <= '0;
                    end
                end
                ST_PTR_WAIT: begin
                    if (mem_rvalid) begin
                        rec_addr_q <= field_to_byte(mem_rdata);
                        last_ptr_q <= mem_rdata[LAST_BIT];
                        ptr_addr_q <= ptr_addr_q + 32'd4;
                        widx_q     <= '0;
                    end
                end
                ST_REC_WAIT: begin
                    if (mem_rvalid) begin
                        widx_q <= widx_q + 1'b1;
                        if (bad_rec_mode) err_q <= 1'b1;
                    end
                end
                ST_DESC: begin
                    if (desc_ready) begin
                        rec_addr_q <= rec_addr_q + WORD_W'(REC_BYTES);
                        widx_q     <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // record staging words
    always_ff @(posedge clk) begin
        if (state_q == ST_REC_WAIT && mem_rvalid) begin
            rec_q[widx_q] <= mem_rdata;
        end
    end
endmodule

// File: rtl/cls_host_if.sv
module cls_host_if #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_irq_en,
    input  logic             idle,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_empty,
    input  logic [31:0]      fifo_head,
    input  logic             rslt_rd,
    output logic [31:0]      status,
    output logic [31:0]      rslt_rdata,
    output logic             irq,
    output logic             fifo_pop
);
    logic irq_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_en_q <= 1'b0;
        else if (cfg_wr) irq_en_q <= cfg_irq_en;
    end

    always_comb begin
        status        = '0;
        status[0]     = idle;
        status[1]     = !fifo_empty;
        status[31:29] = 3'(fifo_count);
    end

    assign rslt_rdata = fifo_empty ? 32'd0 : fifo_head;
    assign fifo_pop   = rslt_rd && !fifo_empty;
    assign irq        = irq_en_q && !fifo_empty;
endmodule

// File: rtl/cmdlist_seq.sv
module cmdlist_seq
    import cls_pkg::*;
#(
    parameter int RES_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cptr_wr,
    input  logic [31:0] cptr_wdata,
    input  logic        cfg_wr,
    input  logic        cfg_irq_en,
    input  logic        rslt_rd,
    output logic [31:0] rslt_rdata,
    output logic [31:0] status,
    output logic        irq,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        desc_valid,
    input  logic        desc_ready,
    output logic [31:0] desc_cmd,
    output logic [31:0] desc_src,
    output logic [31:0] desc_dst,
    output logic [31:0] desc_len
);
    localparam int CNT_W = $clog2(RES_DEPTH + 1);

    logic             idle;
    logic             post_push;
    logic [31:0]      post_word;
    logic             fifo_full, fifo_empty, fifo_pop;
    logic [31:0]      fifo_head;
    logic [CNT_W-1:0] fifo_count;
    desc_t            desc;

    cls_walker u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cptr_wr && idle),
        .start_word (cptr_wdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .desc_valid (desc_valid),
        .desc       (desc),
        .desc_ready (desc_ready),
        .post_ok    (!fifo_full),
        .post_push  (post_push),
        .post_word  (post_word),
        .idle       (idle)
    );

    cls_result_fifo #(.DEPTH(RES_DEPTH), .WIDTH(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (post_push),
        .push_data (post_word),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .count     (fifo_count)
    );

    cls_host_if #(.CNT_W(CNT_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_irq_en (cfg_irq_en),
        .idle       (idle),
        .fifo_count (fifo_count),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .rslt_rd    (rslt_rd),
        .status     (status),
        .rslt_rdata (rslt_rdata),
        .irq        (irq),
        .fifo_pop   (fifo_pop)
    );

    assign desc_cmd = desc.cmd;
    assign desc_src = desc.src;
    assign desc_dst = desc.dst;
    assign desc_len = desc.len;
endmodule

// File: rtl/cmdlist_seq_chk.sv
module cmdlist_seq_chk #(
    parameter int DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cptr_wr,
    input logic        cfg_wr,
    input logic        cfg_irq_en,
    input logic        rslt_rd,
    input logic [31:0] rslt_rdata,
    input logic [31:0] status,
    input logic        irq,
    input logic        mem_req,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic [31:0] desc_cmd,
    input logic [31:0] desc_src,
    input logic [31:0] desc_dst,
    input logic [31:0] desc_len
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cptr_wr && status[0]) |=> !status[0]);

    p_single_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_desc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_cmd) &&
            $stable(desc_src) && $stable(desc_dst) && $stable(desc_len)));

    p_valid_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> rslt_rdata[31]);

    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1] |-> (rslt_rdata == 32'd0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (!mem_req && !desc_valid));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(status[31:29]) <= DEPTH);

    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(status[31:29]) == DEPTH && !rslt_rd) |=> (int'(status[31:29]) == DEPTH));

    p_irq_needs_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status[1]);

    p_irq_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_irq_en) |=> !irq);
endmodule

bind cmdlist_seq cmdlist_seq_chk #(.DEPTH(RES_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cptr_wr    (cptr_wr),
    .cfg_wr     (cfg_wr),
    .cfg_irq_en (cfg_irq_en),
    .rslt_rd    (rslt_rd),
    .rslt_rdata (rslt_rdata),
    .status     (status),
    .irq        (irq),
    .mem_req    (mem_req),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_cmd   (desc_cmd),
    .desc_src   (desc_src),
    .desc_dst   (desc_dst),
    .desc_len   (desc_len)
);

// File: tb/cmdlist_seq_tb.sv
module cmdlist_seq_tb;
    localparam int DEPTH = 4;
    localparam logic [31:0] RES_OK  = 32'h8000_0002;
    localparam logic [31:0] RES_ERR = 32'h8000_0008;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cptr_wr, cfg_wr, cfg_irq_en, rslt_rd;
    logic [31:0] cptr_wdata;
    logic [31:0] rslt_rdata, status;
    logic        irq, mem_req, mem_rvalid, desc_valid, desc_ready;
    logic [31:0] mem_addr, mem_rdata;
    logic [31:0] desc_cmd, desc_src, desc_dst, desc_len;

    always #4 clk = ~clk;

    cmdlist_seq #(.RES_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cptr_wr(cptr_wr), .cptr_wdata(cptr_wdata),
        .cfg_wr(cfg_wr), .cfg_irq_en(cfg_irq_en),
        .rslt_rd(rslt_rd), .rslt_rdata(rslt_rdata),
        .status(status), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_cmd(desc_cmd), .desc_src(desc_src),
        .desc_dst(desc_dst), .desc_len(desc_len)
    );

    logic [31:0]  mem [1024];
    logic [127:0] got_q[$];
    logic [127:0] exp_q[$];
    logic [31:0]  req_log[$];
    logic [31:0]  exp_res, exp_first;
    bit           exp_noreq;
    int           stall_pct = 0;
    int           n_chk = 0, n_err = 0;
    bit           done = 0;

    // memory responder and downstream sink, both act at the falling edge
    bit          pend = 0;
    int          pend_cnt;
    logic [31:0] pend_addr;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend && pend_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[pend_addr[11:2]];
            pend       = 0;
        end else if (pend) begin
            pend_cnt--;
        end
        if (rst_n && mem_req) begin
            pend      = 1;
            pend_addr = mem_addr;
            pend_cnt  = int'($urandom % 3);
            req_log.push_back(mem_addr);
        end
        desc_ready = (int'($urandom % 100) >= stall_pct);
        if (rst_n && desc_valid && desc_ready)
            got_q.push_back({desc_cmd, desc_src, desc_dst, desc_len});
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    // independent walk over the bench memory
    task automatic model_walk(input logic [31:0] cp);
        logic [2:0]  md;
        logic [31:0] pa, ra, pw, c;
        bit          lastp, stop, err;
        md = cp[31:29];
        exp_q.delete();
        err = 0; stop = 0; lastp = 0;
        exp_first = {cp[28:0], 3'b000};
        exp_noreq = (md > 3'd1);
        if (md > 3'd1) begin
            exp_res = RES_ERR;
            return;
        end
        pa = exp_first; ra = exp_first;
        for (int g = 0; g < 16 && !stop; g++) begin
            if (md == 3'd1) begin
                pw = mrd(pa); pa += 4;
                ra = {pw[28:0], 3'b000};
                lastp = pw[31];
            end else begin
                lastp = 1;
            end
            for (int k = 0; k < 16; k++) begin
                c = mrd(ra);
                if (c[1:0] != 2'b00) begin
                    err = 1; stop = 1;
                    break;
                end
                exp_q.push_back({c, mrd(ra + 4), mrd(ra + 8), mrd(ra + 12)});
                ra += 16;
                if (c[31]) break;
            end
            if (lastp) stop = 1;
        end
        exp_res = err ? RES_ERR : RES_OK;
    endtask

    task automatic build_walk(input bit ptr_mode, input int np, input bit bad,
                              output logic [31:0] cp);
        int pbase, arr, nr, badp, badr;
        logic [31:0] c;
        pbase = 2 * int'($urandom % 8);
        arr   = 64;
        badp  = int'($urandom % np);
        for (int p = 0; p < np; p++) begin
            nr   = 1 + int'($urandom % 3);
            badr = int'($urandom % nr);
            if (ptr_mode)
                mem[pbase + p] = {(p == np - 1), 2'($urandom), 29'(arr / 2)};
            for (int r = 0; r < nr; r++) begin
                c = {(r == nr - 1), 29'($urandom), 2'b00};
                if (bad && p == badp && r == badr) c[1:0] = 2'(1 + $urandom % 3);
                mem[arr]     = c;
                mem[arr + 1] = $urandom;
                mem[arr + 2] = $urandom;
                mem[arr + 3] = $urandom;
                arr += 4;
            end
        end
        cp = ptr_mode ? {3'd1, 29'(pbase / 2)} : {3'd0, 29'(64 / 2)};
    endtask

    task automatic start_walk(input logic [31:0] cp);
        model_walk(cp);
        got_q.delete();
        req_log.delete();
        cptr_wr = 1'b1; cptr_wdata = cp;
        @(negedge clk);
        cptr_wr = 1'b0;
        chk("R2 idle drops after write", {31'd0, status[0]}, 32'd0);
    endtask

    task automatic pop_result();
        rslt_rd = 1'b1;
        @(negedge clk);
        rslt_rd = 1'b0;
    endtask

    task automatic finish_walk(input string tag, input bit do_pop);
        int t = 0;
        while (!status[0] && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " R2 walk returns idle"}, {31'd0, status[0]}, 32'd1);
        chk({tag, " R3 R5 descriptor count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            chk({tag, " R4 cmd"}, got_q[i][127:96], exp_q[i][127:96]);
            chk({tag, " R4 src/dst/len"}, got_q[i][95:64] ^ got_q[i][63:32] ^ got_q[i][31:0],
                exp_q[i][95:64] ^ exp_q[i][63:32] ^ exp_q[i][31:0]);
            chk({tag, " R4 len"}, got_q[i][31:0], exp_q[i][31:0]);
        end
        if (exp_noreq)
            chk({tag, " R7 no reads"}, req_log.size(), 0);
        else
            chk({tag, " R2 first read address"}, (req_log.size() > 0) ? req_log[0] : 32'hdead_beef,
                exp_first);
        if (do_pop) begin
            chk({tag, " R9 status one result"}, status, 32'h2000_0003);
            chk({tag, " R8 R6 result word"}, rslt_rdata, exp_res);
            pop_result();
            chk({tag, " R8 empty after read"}, rslt_rdata, 32'd0);
        end
    endtask

    task automatic set_irq(input bit v);
        cfg_wr = 1'b1; cfg_irq_en = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] cp;
        int unused_seed;
        unused_seed = int'($urandom(32'd20250611));
        rst_n = 1'b0; cptr_wr = 1'b0; cptr_wdata = '0; cfg_wr = 1'b0;
        cfg_irq_en = 1'b0; rslt_rd = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        desc_ready = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[200] = 32'h8000_0000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status, 32'h0000_0001);
        chk("R1 irq/req/valid", {29'd0, irq, mem_req, desc_valid}, 32'd0);
        chk("R1 R8 empty result read", rslt_rdata, 32'd0);

        // R7 unsupported list modes
        start_walk(32'h4000_0010);
        finish_walk("R7 mode2", 1);
        start_walk(32'hE000_0000);
        finish_walk("R7 mode7", 1);

        // R5 direct mode, R3 pointer chain, R6 bad record
        build_walk(0, 1, 0, cp); start_walk(cp); finish_walk("R5 direct", 1);
        build_walk(1, 4, 0, cp); start_walk(cp); finish_walk("R3 chain4", 1);
        build_walk(1, 3, 1, cp); start_walk(cp); finish_walk("R6 bad rec", 1);
        build_walk(0, 1, 1, cp); start_walk(cp); finish_walk("R6 bad direct", 1);

        // R11 pointer write while busy is ignored
        stall_pct = 100;
        build_walk(1, 2, 0, cp); start_walk(cp);
        repeat (30) @(negedge clk);
        chk("R11 busy", {31'd0, status[0]}, 32'd0);
        cptr_wr = 1'b1; cptr_wdata = {3'd0, 29'(200 * 4 / 8)};
        @(negedge clk);
        cptr_wr = 1'b0;
        stall_pct = 0;
        finish_walk("R11 ignored write", 1);
        repeat (5) @(negedge clk);
        chk("R11 no extra result", status, 32'h0000_0001);

        // R10 R12 queue fill with interrupt enabled
        set_irq(1);
        for (int i = 0; i < DEPTH; i++) begin
            build_walk(1, 1 + i % 2, 0, cp); start_walk(cp); finish_walk("R10 fill", 0);
        end
        chk("R10 R9 full count", {29'd0, status[31:29]}, 32'(DEPTH));
        chk("R12 irq on", {31'd0, irq}, 32'd1);
        build_walk(0, 1, 0, cp); start_walk(cp);
        repeat (40) @(negedge clk);
        chk("R10 stalled not idle", {31'd0, status[0]}, 32'd0);
        chk("R10 count stays full", {29'd0, status[31:29]}, 32'(DEPTH));
        chk("R8 head result", rslt_rdata, RES_OK);
        pop_result();
        finish_walk("R10 released", 0);
        chk("R10 full again", {29'd0, status[31:29]}, 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            chk("R8 drain", rslt_rdata, RES_OK);
            pop_result();
        end
        chk("R8 drained read", rslt_rdata, 32'd0);
        chk("R12 irq off when empty", {31'd0, irq}, 32'd0);

        // R12 enable gating
        set_irq(0);
        build_walk(0, 1, 0, cp); start_walk(cp); finish_walk("R12 masked", 0);
        chk("R12 masked irq", {31'd0, irq}, 32'd0);
        set_irq(1);
        chk("R12 enabled irq", {31'd0, irq}, 32'd1);
        pop_result();
        chk("R12 irq after pop", {31'd0, irq}, 32'd0);

        // constrained random walks
        for (int it = 0; it < 30; it++) begin
            bit pm, bad;
            int np;
            pm  = ($urandom % 4) != 0;
            np  = pm ? 1 + int'($urandom % 4) : 1;
            bad = ($urandom % 5) == 0;
            case ($urandom % 3)
                0:       stall_pct = 0;
                1:       stall_pct = 30;
                default: stall_pct = 70;
            endcase
            build_walk(pm, np, bad, cp);
            start_walk(cp);
            finish_walk("R3 R4 R6 random", 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule